// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table with Pending Array

This block holds the per-function state for extended message-signalled interrupts. A 12-byte capability header is visible through byte-wide configuration accesses. A table of message entries and a pending-bit array are visible through a memory-style port that carries a byte offset and an access size.

Each table entry supplies a 64-bit message address, a 32-bit message payload and a vector-control word whose bit 0 masks that vector. A one-cycle pulse on a vector's request line either launches that vector's message on a valid/ready output or parks the request in the pending array. Which path it takes depends on the effective mask: the global function mask OR the entry's own mask, evaluated only while the block is enabled. A parked request is launched as soon as its effective mask clears.

The message output obeys the usual stream rules. Once `msg_valid` is high, it stays high with `msg_addr`, `msg_data` and `msg_vec` frozen until a cycle in which `msg_ready` is high. A new message may be loaded in the same cycle the previous one is accepted. When several vectors are ready to go in the same cycle, the lowest index goes first.

Top module: `vecmsg_ctl`

## Requirements
- R1: After reset the block is disabled and not function-masked, every table byte reads 0, the pending array reads 0 and no message is offered.
- R2: A configuration write changes state only at byte offset 3. Bit 7 of that byte becomes the enable (control bit 15) and bit 6 becomes the function mask (control bit 14). Table-size bits 10:0 and reserved bits 13:11 never change, and writes to any other offset are ignored.
- R3: Configuration byte reads are little-endian: offset 0 = capability ID, offset 1 = next pointer, offsets 2-3 = control word, offsets 4-7 = table locator, offsets 8-11 = pending-array locator. Offsets 12-15 read 0xFF. The table-size field reads NUM_VEC-1.
- R4: Each locator carries the region selector parameter in bits 2:0 and the offset parameter in bits 31:3, with the offset's low three bits dropped.
- R5: With `mem_pba`=0, `mem_addr[MEM_AW-1:4]` selects the entry and `mem_addr[3:0]` selects the byte within it. The entry layout is address low at +0, address high at +4, payload at +8 and vector control at +0xC. `mem_size` codes 0,1,2,3 mean 1,2,4,8 bytes, placed little-endian in `mem_wdata`/`mem_rdata`. Read lanes above the access size return 0.
- R6: A table access whose byte offset plus size exceeds 16 is rejected. A read returns 0xFF in every requested lane, and a write changes nothing.
- R7: While enabled and with both masks clear, a request on vector v produces a message carrying {address high, address low}, the payload of entry v and index v. `msg_valid` rises the cycle after the request edge when the output is free.
- R8: With vector-control bit 0 set, a request stays pending and the pending array shows its bit. Clearing the mask launches the message and clears the bit.
- R9: While the function mask is set, every vector is held and changing entry masks launches nothing. When the function mask is cleared, only vectors whose own mask is clear are launched.
- R10: While disabled, requests are dropped, the pending array reads 0 and pending requests are discarded, so they are not launched later.
- R11: While `msg_valid` is high and `msg_ready` is low, the message fields hold still. Among vectors deliverable in the same cycle, the lowest index is launched first.
- R12: With `mem_pba`=1, a read returns 64-bit word `mem_addr[MEM_AW-1:3]` of the pending array, where bit i is vector 64*word+i. Writes to this region are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 4 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte (combinational) |
| mem_we | input | 1 | Memory-port write strobe |
| mem_pba | input | 1 | 1 selects the pending array, 0 the table |
| mem_addr | input | MEM_AW | Byte offset in the selected region |
| mem_size | input | 2 | Access size code (1,2,4,8 bytes) |
| mem_wdata | input | 64 | Write data, little-endian lanes |
| mem_rdata | output | 64 | Read data (combinational) |
| vec_req | input | NUM_VEC | Per-vector request pulses |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted when high with valid |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message payload |
| msg_vec | output | IDX_W | Vector index of the message |

## Verification
Two deliverable vectors can compete for the single output slot in the same cycle. The bench provokes this by holding `msg_ready` low and pulsing two unmasked vectors together. It judges the result by requiring the lower index to appear first, with frozen fields, and both messages to arrive once ready returns. A second collision is a function-mask release that meets one pending vector still masked by its entry; the check is that exactly one message leaves and the pending array keeps the other bit.

// File: rtl/vm_pkg.sv
package vm_pkg;
  localparam int ENTRY_BYTES = 16;
  localparam int ENTRY_BITS  = ENTRY_BYTES * 8;
  // field positions inside one packed entry
  localparam int F_ADDR_LO = 0;
  localparam int F_ADDR_HI = 32;
  localparam int F_DATA    = 64;
  localparam int F_VCTL    = 96;

  typedef enum logic [1:0] {SZ_B1 = 2'd0, SZ_B2 = 2'd1, SZ_B4 = 2'd2, SZ_B8 = 2'd3} acc_size_e;

  function automatic logic [4:0] size_bytes(input logic [1:0] code);
    return 5'd1 << code;
  endfunction
endpackage

// File: rtl/vm_cap.sv
module vm_cap #(
  parameter int          NUM_VEC  = 8,
  parameter logic [7:0]  CAP_ID   = 8'h11,
  parameter logic [7:0]  NEXT_PTR = 8'h00,
  parameter logic [2:0]  TBL_BIR  = 3'd2,
  parameter logic [31:0] TBL_OFF  = 32'h0000_2000,
  parameter logic [2:0]  PBA_BIR  = 3'd3,
  parameter logic [31:0] PBA_OFF  = 32'h0000_3004
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [3:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic       ctl_en,
  output logic       ctl_fmask
);
  localparam logic [10:0] SIZE_M1 = 11'(NUM_VEC - 1);
  localparam logic [31:0] TBL_LOC = {TBL_OFF[31:3], TBL_BIR};
  localparam logic [31:0] PBA_LOC = {PBA_OFF[31:3], PBA_BIR};

  logic [15:0] ctl_word;
  assign ctl_word = {ctl_en, ctl_fmask, 3'b000, SIZE_M1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en    <= 1'b0;
      ctl_fmask <= 1'b0;
    end else if (cfg_we && cfg_addr == 4'd3) begin
      ctl_en    <= cfg_wdata[7];
      ctl_fmask <= cfg_wdata[6];
    end
  end

  always_comb begin
    case (cfg_addr)
      4'd0:    cfg_rdata = CAP_ID;
      4'd1:    cfg_rdata = NEXT_PTR;
      4'd2:    cfg_rdata = ctl_word[7:0];
      4'd3:    cfg_rdata = ctl_word[15:8];
      4'd4:    cfg_rdata = TBL_LOC[7:0];
      4'd5:    cfg_rdata = TBL_LOC[15:8];
      4'd6:    cfg_rdata = TBL_LOC[23:16];
      4'd7:    cfg_rdata = TBL_LOC[31:24];
      4'd8:    cfg_rdata = PBA_LOC[7:0];
      4'd9:    cfg_rdata = PBA_LOC[15:8];
      4'd10:   cfg_rdata = PBA_LOC[23:16];
      4'd11:   cfg_rdata = PBA_LOC[31:24];
      default: cfg_rdata = 8'hFF;
    endcase
  end

  // R2: writes away from offset 3 leave the control state alone
  a_r2_other_offsets_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr != 4'd3) |=> ($stable(ctl_en) && $stable(ctl_fmask)));
endmodule

// File: rtl/vm_store.sv
module vm_store
  import vm_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int IDX_W   = $clog2(NUM_VEC),
  parameter int MEM_AW  = IDX_W + 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mem_we,
  input  logic               mem_pba,
  input  logic [MEM_AW-1:0]  mem_addr,
  input  logic [1:0]         mem_size,
  input  logic [63:0]        mem_wdata,
  output logic [63:0]        mem_rdata,
  input  logic [NUM_VEC-1:0] pend_vis,
  input  logic [IDX_W-1:0]   look_idx,
  output logic [63:0]        look_addr,
  output logic [31:0]        look_data,
  output logic [NUM_VEC-1:0] vmask
);
  localparam int PBA_Q = (NUM_VEC + 63) / 64;
  localparam int PBA_W = PBA_Q * 64;

  logic [ENTRY_BITS-1:0] ent [NUM_VEC];

  logic [IDX_W-1:0]  idx;
  logic [3:0]        off;
  logic [4:0]        nbytes;
  logic              straddle;
  logic              in_range;
  logic [8:0]        lanes9;
  logic [63:0]       lane_mask;
  logic [ENTRY_BITS-1:0] shifted;
  logic [PBA_W-1:0]  pba_pad;
  logic [MEM_AW-4:0] qsel;

  assign idx      = mem_addr[MEM_AW-1:4];
  assign off      = mem_addr[3:0];
  assign nbytes   = size_bytes(mem_size);
  assign straddle = ({1'b0, off} + nbytes) > 5'd16;
  assign in_range = int'(idx) < NUM_VEC;
  assign lanes9   = (9'd1 << nbytes) - 9'd1;
  assign qsel     = mem_addr[MEM_AW-1:3];

  always_comb begin
    for (int b = 0; b < 8; b++) lane_mask[b*8 +: 8] = {8{lanes9[b]}};
  end

  always_comb begin
    pba_pad = '0;
    pba_pad[NUM_VEC-1:0] = pend_vis;
  end

  assign shifted = ent[idx] >> {off, 3'b000};

  always_comb begin
    if (mem_pba) begin
      mem_rdata = (int'(qsel) < PBA_Q) ? pba_pad[int'(qsel)*64 +: 64] : 64'd0;
    end else if (straddle || !in_range) begin
      mem_rdata = lane_mask;
    end else begin
      mem_rdata = shifted[63:0] & lane_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VEC; i++) ent[i] <= '0;
    end else if (mem_we && !mem_pba && !straddle && in_range) begin
      for (int b = 0; b < ENTRY_BYTES; b++) begin
        if (b >= int'(off) && b < int'(off) + int'(nbytes))
          ent[idx][b*8 +: 8] <= mem_wdata[(b - int'(off))*8 +: 8];
      end
    end
  end

  logic [NUM_VEC*ENTRY_BITS-1:0] flat;
  for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_ent
    assign vmask[gi] = ent[gi][F_VCTL];
    assign flat[gi*ENTRY_BITS +: ENTRY_BITS] = ent[gi];
  end

  assign look_addr = {ent[look_idx][F_ADDR_HI +: 32], ent[look_idx][F_ADDR_LO +: 32]};
  assign look_data = ent[look_idx][F_DATA +: 32];

  // R6: rejected writes leave the table untouched
  a_r6_straddle_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_pba && straddle) |=> $stable(flat));
  // R12: pending-array writes do not reach the table
  a_r12_pba_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_pba) |=> $stable(flat));
endmodule

// File: rtl/vm_launch.sv
module vm_launch #(
  parameter int NUM_VEC = 8,
  parameter int IDX_W   = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_en,
  input  logic               ctl_fmask,
  input  logic [NUM_VEC-1:0] vmask,
  input  logic [NUM_VEC-1:0] vec_req,
  output logic [IDX_W-1:0]   look_idx,
  input  logic [63:0]        look_addr,
  input  logic [31:0]        look_data,
  output logic [NUM_VEC-1:0] pend_vis,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data,
  output logic [IDX_W-1:0]   msg_vec
);
  logic [NUM_VEC-1:0] pend;
  logic [NUM_VEC-1:0] eff_mask;
  logic [NUM_VEC-1:0] dlv;
  logic [NUM_VEC-1:0] grant_oh;
  logic [IDX_W-1:0]   pick;
  logic               slot_free;
  logic               fire;

  assign eff_mask  = {NUM_VEC{ctl_fmask}} | vmask;
  assign dlv       = pend & ~eff_mask & {NUM_VEC{ctl_en}};
  assign pend_vis  = pend & eff_mask & {NUM_VEC{ctl_en}};
  assign slot_free = !msg_valid || msg_ready;
  assign fire      = slot_free && (|dlv);
  assign look_idx  = pick;
  assign grant_oh  = fire ? (NUM_VEC'(1) << pick) : '0;

  always_comb begin
    pick = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) if (dlv[i]) pick = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else if (!ctl_en) pend <= '0;
    else pend <= (pend & ~grant_oh) | vec_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      msg_vec   <= '0;
    end else if (fire) begin
      msg_valid <= 1'b1;
      msg_addr  <= look_addr;
      msg_data  <= look_data;
      msg_vec   <= pick;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // R11: stalled message holds its fields
  a_r11_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data) && $stable(msg_vec)));
  // R7: a freshly loaded message belongs to a vector that was deliverable
  a_r7_from_deliverable: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (!$past(msg_valid) || $past(msg_ready))) |-> (|($past(dlv) >> msg_vec)));
  // R10: disabled means nothing is kept pending
  a_r10_disabled_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> (pend == '0));
endmodule

// File: rtl/vecmsg_ctl.sv
module vecmsg_ctl #(
  parameter int          NUM_VEC  = 8,
  parameter logic [7:0]  CAP_ID   = 8'h11,
  parameter logic [7:0]  NEXT_PTR = 8'h00,
  parameter logic [2:0]  TBL_BIR  = 3'd2,
  parameter logic [31:0] TBL_OFF  = 32'h0000_2000,
  parameter logic [2:0]  PBA_BIR  = 3'd3,
  parameter logic [31:0] PBA_OFF  = 32'h0000_3004,
  localparam int         IDX_W    = $clog2(NUM_VEC),
  localparam int         MEM_AW   = IDX_W + 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [3:0]         cfg_addr,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  input  logic               mem_we,
  input  logic               mem_pba,
  input  logic [MEM_AW-1:0]  mem_addr,
  input  logic [1:0]         mem_size,
  input  logic [63:0]        mem_wdata,
  output logic [63:0]        mem_rdata,
  input  logic [NUM_VEC-1:0] vec_req,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data,
  output logic [IDX_W-1:0]   msg_vec
);
  logic               ctl_en, ctl_fmask;
  logic [NUM_VEC-1:0] vmask, pend_vis;
  logic [IDX_W-1:0]   look_idx;
  logic [63:0]        look_addr;
  logic [31:0]        look_data;

  vm_cap #(
    .NUM_VEC(NUM_VEC), .CAP_ID(CAP_ID), .NEXT_PTR(NEXT_PTR),
    .TBL_BIR(TBL_BIR), .TBL_OFF(TBL_OFF), .PBA_BIR(PBA_BIR), .PBA_OFF(PBA_OFF)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ctl_en(ctl_en), .ctl_fmask(ctl_fmask)
  );

  vm_store #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W), .MEM_AW(MEM_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_pba(mem_pba),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pend_vis(pend_vis), .look_idx(look_idx),
    .look_addr(look_addr), .look_data(look_data), .vmask(vmask)
  );

  vm_launch #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_launch (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_fmask(ctl_fmask),
    .vmask(vmask), .vec_req(vec_req), .look_idx(look_idx),
    .look_addr(look_addr), .look_data(look_data), .pend_vis(pend_vis),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data), .msg_vec(msg_vec)
  );
endmodule

// File: tb/vecmsg_ctl_tb.sv
`timescale 1ns/1ps
module vecmsg_ctl_tb;
  localparam int NV = 8;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic mem_we = 1'b0, mem_pba = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic [1:0] mem_size = '0;
  logic [63:0] mem_wdata = '0, mem_rdata;
  logic [NV-1:0] vec_req = '0;
  logic msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  logic [2:0] msg_vec;

  int tests = 0, fails = 0, n_msg = 0;
  logic [63:0] last_addr;
  logic [31:0] last_data;
  logic [2:0]  last_vec;
  logic [127:0] mdl [NV];
  bit done = 0;

  always #2.5 clk = ~clk;

  vecmsg_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_we(mem_we),
    .mem_pba(mem_pba), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .vec_req(vec_req),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data), .msg_vec(msg_vec)
  );

  always @(posedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      n_msg++;
      last_addr = msg_addr;
      last_data = msg_data;
      last_vec  = msg_vec;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); cfg_addr = a; #1 v = cfg_rdata;
  endtask

  task automatic cfg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic mem_wr(input logic pba, input int v, input int off, input logic [1:0] sz, input logic [63:0] d);
    @(negedge clk); mem_we = 1'b1; mem_pba = pba; mem_addr = AW'(v*16 + off); mem_size = sz; mem_wdata = d;
    @(negedge clk); mem_we = 1'b0;
  endtask

  task automatic mem_rd(input logic pba, input int v, input int off, input logic [1:0] sz, output logic [63:0] d);
    @(negedge clk); mem_pba = pba; mem_addr = AW'(v*16 + off); mem_size = sz; #1 d = mem_rdata;
  endtask

  function automatic logic [63:0] exp_rd(input int v, input int off, input int n);
    logic [63:0] r = '0;
    if (off + n > 16) begin
      for (int b = 0; b < n; b++) r[b*8 +: 8] = 8'hFF;
    end else begin
      for (int b = 0; b < n; b++) r[b*8 +: 8] = mdl[v][(off+b)*8 +: 8];
    end
    return r;
  endfunction

  task automatic mdl_wr(input int v, input int off, input int n, input logic [63:0] d);
    if (off + n <= 16)
      for (int b = 0; b < n; b++) mdl[v][(off+b)*8 +: 8] = d[b*8 +: 8];
  endtask

  task automatic tbl_wr(input int v, input int off, input logic [1:0] sz, input logic [63:0] d);
    mdl_wr(v, off, 1 << sz, d);
    mem_wr(1'b0, v, off, sz, d);
  endtask

  task automatic pulse(input logic [NV-1:0] m);
    @(negedge clk); vec_req = m;
    @(negedge clk); vec_req = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b8;
    logic [63:0] q;
    int c0;
    void'($urandom(32'd1234));
    for (int i = 0; i < NV; i++) mdl[i] = '0;
    idle(4); rst_n = 1'b1; idle(2);

    // R1 reset state
    cfg_rd(2, b8); check("R1 ctl low", 64'(b8), 64'h07);
    cfg_rd(3, b8); check("R1 ctl high", 64'(b8), 64'h00);
    mem_rd(1'b0, 3, 0, 2'd3, q); check("R1 entry zero", q, 64'd0);
    mem_rd(1'b1, 0, 0, 2'd3, q); check("R1 pba zero", q, 64'd0);
    check("R1 no message", 64'(msg_valid), 64'd0);

    // R3 header layout
    cfg_rd(0, b8); check("R3 cap id", 64'(b8), 64'h11);
    cfg_rd(1, b8); check("R3 next ptr", 64'(b8), 64'h00);
    cfg_rd(12, b8); check("R3 past end", 64'(b8), 64'hFF);
    cfg_rd(15, b8); check("R3 past end", 64'(b8), 64'hFF);

    // R4 locators
    cfg_rd(4, b8); check("R4 tbl loc b0", 64'(b8), 64'h02);
    cfg_rd(5, b8); check("R4 tbl loc b1", 64'(b8), 64'h20);
    cfg_rd(8, b8); check("R4 pba loc b0", 64'(b8), 64'h03);
    cfg_rd(9, b8); check("R4 pba loc b1", 64'(b8), 64'h30);

    // R2 writable control bits
    cfg_wr(2, 8'hFF); cfg_rd(2, b8); check("R2 offset 2 ignored", 64'(b8), 64'h07);
    cfg_wr(3, 8'hFF); cfg_rd(3, b8); check("R2 only bits 15:14", 64'(b8), 64'hC0);
    cfg_rd(2, b8); check("R2 size kept", 64'(b8), 64'h07);
    cfg_wr(3, 8'h80); cfg_rd(3, b8); check("R2 enable only", 64'(b8), 64'h80);

    // R5 random table writes and readback
    for (int it = 0; it < 40; it++) begin
      int v, off, n;
      logic [1:0] sz;
      logic [63:0] d;
      v = int'($urandom % NV);
      sz = 2'($urandom % 4);
      n = 1 << sz;
      off = int'($urandom % (13 - n));
      d = {$urandom, $urandom};
      tbl_wr(v, off, sz, d);
      mem_rd(1'b0, v, 0, 2'd3, q); check("R5 readback lo", q, exp_rd(v, 0, 8));
      mem_rd(1'b0, v, 8, 2'd2, q); check("R5 readback data", q, exp_rd(v, 8, 4));
    end
    mem_rd(1'b0, 4, 2, 2'd1, q); check("R5 narrow read", q, exp_rd(4, 2, 2));

    // R6 straddling accesses
    mem_rd(1'b0, 2, 12, 2'd3, q); check("R6 straddle read 8", q, 64'hFFFF_FFFF_FFFF_FFFF);
    mem_rd(1'b0, 2, 15, 2'd1, q); check("R6 straddle read 2", q, 64'h0000_0000_0000_FFFF);
    mem_wr(1'b0, 2, 12, 2'd3, 64'h1111_2222_3333_0001);
    mem_rd(1'b0, 2, 12, 2'd2, q); check("R6 straddle write vctl", q, exp_rd(2, 12, 4));
    mem_rd(1'b0, 2, 8, 2'd2, q); check("R6 straddle write data", q, exp_rd(2, 8, 4));

    // R7 unmasked launch
    c0 = n_msg; pulse(8'h20); idle(4);
    check("R7 one message", 64'(n_msg - c0), 64'd1);
    check("R7 vec", 64'(last_vec), 64'd5);
    check("R7 addr", last_addr, mdl[5][63:0]);
    check("R7 data", 64'(last_data), 64'(mdl[5][95:64]));

    // R8 per-vector mask
    tbl_wr(1, 12, 2'd2, 64'd1);
    c0 = n_msg; pulse(8'h02); idle(4);
    check("R8 held", 64'(n_msg - c0), 64'd0);
    mem_rd(1'b1, 0, 0, 2'd3, q); check("R8 pba set", q, 64'h02);
    tbl_wr(1, 12, 2'd2, 64'd0); idle(4);
    check("R8 released", 64'(n_msg - c0), 64'd1);
    check("R8 vec", 64'(last_vec), 64'd1);
    mem_rd(1'b1, 0, 0, 2'd3, q); check("R8 pba clear", q, 64'h00);

    // R9 function mask precedence
    cfg_wr(3, 8'hC0);
    tbl_wr(2, 12, 2'd2, 64'd1);
    c0 = n_msg; pulse(8'h14); idle(4);
    check("R9 all held", 64'(n_msg - c0), 64'd0);
    mem_rd(1'b1, 0, 0, 2'd3, q); check("R9 pba both", q, 64'h14);
    tbl_wr(2, 12, 2'd2, 64'd0); idle(4);
    check("R9 entry unmask no effect", 64'(n_msg - c0), 64'd0);
    mem_rd(1'b1, 0, 0, 2'd3, q); check("R9 pba still both", q, 64'h14);
    tbl_wr(2, 12, 2'd2, 64'd1);
    cfg_wr(3, 8'h80); idle(4);
    check("R9 one released", 64'(n_msg - c0), 64'd1);
    check("R9 unmasked vec", 64'(last_vec), 64'd4);
    mem_rd(1'b1, 0, 0, 2'd3, q); check("R9 masked stays", q, 64'h04);
    tbl_wr(2, 12, 2'd2, 64'd0); idle(4);
    check("R9 second released", 64'(last_vec), 64'd2);

    // R10 disable
    tbl_wr(6, 12, 2'd2, 64'd1);
    pulse(8'h40); idle(2);
    mem_rd(1'b1, 0, 0, 2'd3, q); check("R10 pending before", q, 64'h40);
    cfg_wr(3, 8'h00);
    c0 = n_msg; pulse(8'h08); idle(4);
    check("R10 dropped", 64'(n_msg - c0), 64'd0);
    mem_rd(1'b1, 0, 0, 2'd3, q); check("R10 pba zero", q, 64'h00);
    cfg_wr(3, 8'h80);
    tbl_wr(6, 12, 2'd2, 64'd0); idle(4);
    check("R10 discarded", 64'(n_msg - c0), 64'd0);

    // R11 back-pressure and ordering
    @(negedge clk); msg_ready = 1'b0;
    c0 = n_msg; pulse(8'h48); idle(3);
    check("R11 valid", 64'(msg_valid), 64'd1);
    check("R11 lowest first", 64'(msg_vec), 64'd3);
    idle(3);
    check("R11 held vec", 64'(msg_vec), 64'd3);
    check("R11 held addr", msg_addr, mdl[3][63:0]);
    @(negedge clk); msg_ready = 1'b1; idle(4);
    check("R11 both delivered", 64'(n_msg - c0), 64'd2);
    check("R11 second vec", 64'(last_vec), 64'd6);

    // R12 pending array writes ignored
    tbl_wr(7, 12, 2'd2, 64'd1);
    pulse(8'h80); idle(2);
    mem_wr(1'b1, 0, 0, 2'd3, 64'd0);
    mem_rd(1'b1, 0, 0, 2'd3, q); check("R12 pba write ignored", q, 64'h80);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule